// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block generates the word address for a four-beat burst. A load strobe captures a base address and an order select. After that, each cycle in which the advance input is high moves the burst one beat forward. Only the two lowest address bits follow the burst order. The upper bits keep the value of the loaded base until the next load.

Two orders are supported. The linear order adds the beat number to the starting offset modulo four. The interleaved order XORs the beat number into the starting offset. Either order can begin at any of the four offsets. After four advances the sequence returns to the starting offset. The beat count output reports how many advances have happened since the load, modulo four.

The address and the beat count come straight from registers through a small offset mapper, so they change only on a clock edge. The reset input is asynchronous and active low. Inside the block it is synchronised to the clock before it is released.

Top module: `burst_addr_gen`

## Requirements
- R1: Once reset has been released and the internal release delay has passed, `addr_o` is zero and `beat_o` is zero.
- R2: A clock edge with `load_i` high makes `addr_o` equal to the `base_i` value sampled at that edge, and makes `beat_o` zero, from that edge onward.
- R3: A clock edge with `adv_i` high and `load_i` low adds one to `beat_o`, modulo four.
- R4: A clock edge with both `load_i` and `adv_i` low leaves `addr_o` and `beat_o` unchanged.
- R5: When `mode_i` was 1 at the last load (interleaved order), `addr_o[1:0]` equals the loaded `base_i[1:0]` XOR `beat_o`.
- R6: When `mode_i` was 0 at the last load (linear order), `addr_o[1:0]` equals the loaded `base_i[1:0]` plus `beat_o`, modulo four.
- R7: `addr_o[ADDR_W-1:2]` stays at the loaded base value until the next load.
- R8: After four advance edges following a load, `addr_o` equals the loaded base again and `beat_o` is zero.
- R9: When `load_i` and `adv_i` are high at the same edge, the load takes effect and `beat_o` becomes zero.
- R10: `mode_i` is sampled only at a load edge. Changing it during a burst has no effect on `addr_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_i | input | 1 | Load strobe: captures the base address and the order and clears the beat count |
| base_i | input | ADDR_W | Base address of the burst |
| adv_i | input | 1 | Advance request: steps the burst by one beat |
| mode_i | input | 1 | Order select, captured at load: 1 selects interleaved, 0 selects linear |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Number of advances since the last load, modulo four |

## Verification
The load strobe and the advance request can arrive on the same clock edge, and the design must let the load win. The bench drives this case in the middle of a running burst, with the beat count not at zero. It then expects the new base address with a zero beat count one edge later, and it follows with further advances to confirm that the burst restarts from the new offset. The bench also toggles the order select during a burst, so that a late change of mode meets the advance logic, and it expects the order latched at the load to stay in force.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  localparam int BEATS  = 1 << BEAT_W;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_i,
  input  logic  step_i,
  output beat_t cnt_o
);
  beat_t cnt_q;
  beat_t cnt_d;
  logic  cnt_en;

  // The clear has priority over the step.
  always_comb begin
    cnt_en = clr_i | step_i;
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + beat_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i) |=> (cnt_o == beat_t'($past(cnt_o) + 1)));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
  import burst_pkg::*;
(
  input  beat_t        start_i,
  input  beat_t        beat_i,
  input  burst_order_e order_i,
  output beat_t        off_o
);
  beat_t lin_off;
  beat_t xor_off;

  always_comb begin
    lin_off = start_i + beat_i;
    xor_off = start_i ^ beat_i;
    off_o   = (order_i == ORD_XOR) ? xor_off : lin_off;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              adv_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        beat_o
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic              rst_sync_n;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_d;
  burst_order_e      order_q;
  burst_order_e      order_d;
  beat_t             beat_cnt;
  beat_t             low_off;

  burst_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // The base address and the order are captured only by a load.
  always_comb begin
    base_d  = base_i;
    order_d = mode_i ? ORD_XOR : ORD_LINEAR;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      base_q  <= '0;
      order_q <= ORD_LINEAR;
    end else if (load_i) begin
      base_q  <= base_d;
      order_q <= order_d;
    end
  end

  burst_beat_ctr u_beat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (load_i),
    .step_i (adv_i),
    .cnt_o  (beat_cnt)
  );

  burst_offset_map u_map (
    .start_i (base_q[BEAT_W-1:0]),
    .beat_i  (beat_cnt),
    .order_i (order_q),
    .off_o   (low_off)
  );

  assign addr_o = {base_q[ADDR_W-1:BEAT_W], low_off};
  assign beat_o = beat_cnt;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_i |=> (addr_o == $past(base_i)) && (beat_o == 2'd0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_i && !adv_i) |=> ($stable(addr_o) && $stable(beat_o)));

  assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !load_i |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])));

  assert_mode_ignored_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_i && !adv_i && (mode_i != $past(mode_i))) |=> $stable(addr_o));

  initial begin
    assert_width_ok: assert (UPPER_W >= 1);
  end
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 12;

  logic          clk;
  logic          rst_n;
  logic          load_i;
  logic [AW-1:0] base_i;
  logic          adv_i;
  logic          mode_i;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;

  int n_tests;
  int n_fail;
  bit done;

  logic [AW-1:0] exp_addr_q[$];
  logic [1:0]    exp_beat_q[$];
  string         exp_tag_q[$];

  logic [AW-1:0] m_base;
  logic [1:0]    m_beat;
  logic          m_xor;

  burst_addr_gen #(.ADDR_W(AW)) u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .base_i (base_i),
    .adv_i  (adv_i),
    .mode_i (mode_i),
    .addr_o (addr_o),
    .beat_o (beat_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] lo;
    lo = m_xor ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic step(input logic ld, input logic [AW-1:0] b, input logic adv,
                      input logic md, input string tag);
    @(negedge clk);
    load_i = ld; base_i = b; adv_i = adv; mode_i = md;
    if (ld) begin
      m_base = b; m_beat = 2'd0; m_xor = md;
    end else if (adv) begin
      m_beat = m_beat + 2'd1;
    end
    @(posedge clk);
    #1;
    exp_addr_q.push_back(model_addr());
    exp_beat_q.push_back(m_beat);
    exp_tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    while (exp_addr_q.size() > 0) begin
      logic [AW-1:0] ea;
      logic [1:0]    eb;
      string         t;
      ea = exp_addr_q.pop_front();
      eb = exp_beat_q.pop_front();
      t  = exp_tag_q.pop_front();
      n_tests++;
      if (addr_o !== ea || beat_o !== eb) begin
        n_fail++;
        $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                 t, addr_o, beat_o, ea, eb);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; load_i = 1'b0; base_i = '0; adv_i = 1'b0; mode_i = 1'b0;
    m_base = '0; m_beat = 2'd0; m_xor = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    n_tests++;
    if (addr_o !== '0 || beat_o !== 2'd0) begin
      n_fail++;
      $display("FAIL R1: addr=%h beat=%0d expected addr=0 beat=0", addr_o, beat_o);
    end

    // R2, R6, R7, R8: linear order from offset 01
    step(1'b1, 12'h5A1, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 4; i++) step(1'b0, 12'h000, 1'b1, 1'b0, "R6_R7_R8");

    // R5, R4, R3: interleaved order from offset 11, with holds between advances
    step(1'b1, 12'h3F3, 1'b0, 1'b1, "R2");
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 12'hFFF, 1'b1, 1'b1, "R5_R3");
      step(1'b0, 12'h000, 1'b0, 1'b1, "R4");
      step(1'b0, 12'h000, 1'b0, 1'b1, "R4");
    end

    // R5, R8: interleaved order from offset 10, then linear from offset 10
    step(1'b1, 12'hA82, 1'b0, 1'b1, "R2");
    for (int i = 0; i < 5; i++) step(1'b0, 12'h000, 1'b1, 1'b1, "R5_R8");
    step(1'b1, 12'hA82, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 5; i++) step(1'b0, 12'h000, 1'b1, 1'b0, "R6_R8");

    // R10: mode toggles mid-burst after a linear load
    step(1'b1, 12'h7C1, 1'b0, 1'b0, "R2");
    step(1'b0, 12'h000, 1'b1, 1'b1, "R10");
    step(1'b0, 12'h000, 1'b0, 1'b0, "R10");
    step(1'b0, 12'h000, 1'b1, 1'b1, "R10");
    step(1'b0, 12'h000, 1'b1, 1'b1, "R10");

    // R10: mode toggles mid-burst after an interleaved load
    step(1'b1, 12'h102, 1'b0, 1'b1, "R2");
    step(1'b0, 12'h000, 1'b1, 1'b0, "R10");
    step(1'b0, 12'h000, 1'b1, 1'b0, "R10");
    step(1'b0, 12'h000, 1'b0, 1'b1, "R10");
    step(1'b0, 12'h000, 1'b1, 1'b0, "R10");

    // R9: load and advance on the same edge, mid-burst with a nonzero beat
    step(1'b1, 12'h240, 1'b0, 1'b0, "R2");
    step(1'b0, 12'h000, 1'b1, 1'b0, "R3");
    step(1'b0, 12'h000, 1'b1, 1'b0, "R3");
    step(1'b1, 12'hE13, 1'b1, 1'b1, "R9");
    for (int i = 0; i < 3; i++) step(1'b0, 12'h000, 1'b1, 1'b1, "R9_R5");

    // R9: back-to-back loads, each with advance held high
    step(1'b1, 12'h0FD, 1'b1, 1'b0, "R9");
    step(1'b1, 12'h8A6, 1'b1, 1'b0, "R9");
    step(1'b0, 12'h000, 1'b1, 1'b0, "R6");

    step(1'b0, 12'h000, 1'b0, 1'b0, "R4");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule